// File: doc/BRIEF.md
# Multi-tap linear sensor pixel reorder

This block sits after the digitizers of a linear image sensor whose line is read through four video taps. Two taps carry the odd pixels and two carry the even pixels. One pair starts at pixel 1 and walks toward the centre. The other pair starts at the far end of the line and walks back toward the centre. Every tap presents a sample word with a valid strobe. The taps may run in lockstep or one after another, so each strobe is taken on its own. Each accepted sample is written at the pixel position its tap and sample count imply.

When all four taps have delivered their share of a line, the filled buffer is handed to a read port. The read port streams pixels 1 to N in spatial order, one per accepted beat, with first-pixel and last-pixel markers. There are two line buffers used alternately, so a new line can fill while the previous one drains. A sticky flag reports lines or samples that could not be taken.

The line length is a parameter, `LINE_PIX`, which must be a multiple of 4. The sensor's full line of 12000 pixels is set at instantiation. The default is a short line so that the buffers stay small when elaborated stand-alone.

Top module: `pixel_reorder`

## Requirements
- R1: After reset, out_valid and overrun are 0.
- R2: The k-th sample (k counted from 1 since the last line_start) on tap 0 (tap_valid[0], tap_data[DATA_W-1:0]) is output as pixel 2k-1. The k-th sample on tap 1 (tap_valid[1], next DATA_W bits) is output as pixel 2k.
- R3: With N = LINE_PIX, the k-th sample on tap 2 is output as pixel N+1-2k, and the k-th sample on tap 3 is output as pixel N+2-2k.
- R4: Each tap's strobe is accepted independently. The same line results whether the taps deliver in lockstep, one tap after another, or in any random interleave.
- R5: Each tap takes N/4 samples per line. line_start clears all four sample counts, so a partial line is abandoned and produces no output. A line is complete once all four counts reach N/4.
- R6: The read port outputs pixels 1 to N in order, one per cycle in which out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_valid and out_data hold.
- R7: out_sol is 1 exactly on pixel 1 and out_eol is 1 exactly on pixel N.
- R8: A completed line is handed to the read port when the read port is idle or is accepting its last pixel. The next line fills the other buffer while the previous one is read.
- R9: A sample strobed on a tap that already holds N/4 samples for the current line is not stored, and it sets overrun.
- R10: A line that completes while the read port is still busy with an earlier line is discarded and sets overrun. The line being read is output unchanged.
- R11: overrun stays 1 until reset, including across line_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_start | input | 1 | Starts a new line: clears the per-tap sample counts |
| tap_valid | input | 4 | Per-tap sample strobe, bit t for tap t |
| tap_data | input | 4*DATA_W | Per-tap sample words, tap t in bits [t*DATA_W +: DATA_W] |
| out_ready | input | 1 | Downstream accepts the current pixel |
| out_valid | output | 1 | A pixel is presented |
| out_data | output | DATA_W | Pixel value |
| out_sol | output | 1 | Presented pixel is pixel 1 |
| out_eol | output | 1 | Presented pixel is pixel N |
| overrun | output | 1 | Sticky: an extra sample or a dropped line was seen |

## Verification
The hardest situation to reach is a second line completing while the first still drains. That outcome is either a legal overlap (R8) or a drop (R10), and which one occurs depends on how fill time compares with read time. The stimulus forces both cases deterministically. For the overlap, the read port is held ready and the second line is fed with a gap of at least four idle cycles after each strobe, so its fill time exceeds the read time. For the drop, out_ready is held low while two full-rate lines are fed. The extra-sample case is reached by strobing a tap after its line has completed but before the next line_start.

// File: rtl/pixel_reorder_pkg.sv
package pixel_reorder_pkg;
  localparam int unsigned NUM_TAPS = 4;

  typedef enum logic {
    RD_IDLE,
    RD_STREAM
  } rd_state_e;
endpackage

// File: rtl/pixel_reorder_tap_counter.sv
module pixel_reorder_tap_counter #(
  parameter  int unsigned PER_TAP = 60,
  localparam int unsigned CW      = $clog2(PER_TAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          valid,
  output logic          wr_en,
  output logic [CW-1:0] wr_idx,
  output logic          full,
  output logic          extra
);
  localparam logic [CW-1:0] CNT_MAX = CW'(PER_TAP);

  logic [CW-1:0] cnt_q, cnt_d;

  assign full = (cnt_q == CNT_MAX);

  // a strobe in the line_start cycle becomes sample 1 of the new line
  always_comb begin
    wr_en  = valid && (clr || !full);
    wr_idx = clr ? '0 : cnt_q;
    extra  = valid && !clr && full;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = valid ? CW'(1) : '0;
    end else if (wr_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R5: a tap never holds more than its share of a line
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // R9: once full, extra strobes leave the count untouched
  p_full_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> (full && $stable(cnt_q)));
endmodule

// File: rtl/pixel_reorder_bank.sv
module pixel_reorder_bank #(
  parameter  int unsigned DATA_W = 12,
  parameter  int unsigned DEPTH  = 120,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pixel_reorder_reader.sv
module pixel_reorder_reader
  import pixel_reorder_pkg::*;
#(
  parameter  int unsigned LINE_PIX = 240,
  parameter  int unsigned PER_TAP  = 60,
  localparam int unsigned IW       = $clog2(LINE_PIX),
  localparam int unsigned AW       = $clog2(2 * PER_TAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_buf,
  input  logic          ready,
  output logic          free,
  output logic          out_valid,
  output logic          sol,
  output logic          eol,
  output logic [1:0]    bank_sel,
  output logic [AW-1:0] bank_addr
);
  localparam logic [IW-1:0] LAST_IDX = IW'(LINE_PIX - 1);
  localparam logic [IW-1:0] HALF_IDX = IW'(LINE_PIX / 2);
  localparam logic [AW-1:0] BUF_OFS  = AW'(PER_TAP);

  rd_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          buf_q, buf_d;
  logic          fire, last;
  logic [IW-1:0] mirror;
  logic [AW-1:0] slot;

  assign fire      = (state_q == RD_STREAM) && ready;
  assign last      = (idx_q == LAST_IDX);
  assign free      = (state_q == RD_IDLE) || (fire && last);
  assign out_valid = (state_q == RD_STREAM);
  assign sol       = out_valid && (idx_q == '0);
  assign eol       = out_valid && last;

  // pixel index -> tap bank and slot: lower half forward, upper half mirrored
  always_comb begin
    mirror = LAST_IDX - idx_q;
    if (idx_q < HALF_IDX) begin
      bank_sel = {1'b0, idx_q[0]};
      slot     = AW'(idx_q >> 1);
    end else begin
      bank_sel = {1'b1, idx_q[0]};
      slot     = AW'(mirror >> 1);
    end
    bank_addr = buf_q ? slot + BUF_OFS : slot;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    buf_d   = buf_q;
    if (load) begin
      state_d = RD_STREAM;
      idx_d   = '0;
      buf_d   = load_buf;
    end else if (fire) begin
      if (last) begin
        state_d = RD_IDLE;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
      buf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      buf_q   <= buf_d;
    end
  end

  // R6: an accepted non-final pixel is always followed by another pixel
  p_stream_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ready && !eol) |=> out_valid);

  // R7: after the last pixel the port is idle or restarts at pixel 1
  p_eol_then_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ready && eol) |=> (!out_valid || sol));
endmodule

// File: rtl/pixel_reorder.sv
module pixel_reorder
  import pixel_reorder_pkg::*;
#(
  parameter  int unsigned LINE_PIX = 240,
  parameter  int unsigned DATA_W   = 12,
  localparam int unsigned PER_TAP  = LINE_PIX / 4,
  localparam int unsigned CW       = $clog2(PER_TAP + 1),
  localparam int unsigned AW       = $clog2(2 * PER_TAP)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_start,
  input  logic [NUM_TAPS-1:0]        tap_valid,
  input  logic [NUM_TAPS*DATA_W-1:0] tap_data,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          out_data,
  output logic                       out_sol,
  output logic                       out_eol,
  output logic                       overrun
);
  localparam logic [AW-1:0] BUF_OFS = AW'(PER_TAP);

  logic [1:0]          rst_pipe;
  logic                rst_s;
  logic [NUM_TAPS-1:0] wr_en, full, extra;
  logic [CW-1:0]       wr_idx [NUM_TAPS];
  logic [AW-1:0]       waddr  [NUM_TAPS];
  logic [DATA_W-1:0]   rdata  [NUM_TAPS];
  logic [AW-1:0]       raddr;
  logic [1:0]          bank_sel;
  logic                reader_free;
  logic                done_q, done_d;
  logic                wr_buf_q, wr_buf_d;
  logic                ovr_q, ovr_d;
  logic                line_done, handoff, drop;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    pixel_reorder_tap_counter #(.PER_TAP(PER_TAP)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_s),
      .clr    (line_start),
      .valid  (tap_valid[t]),
      .wr_en  (wr_en[t]),
      .wr_idx (wr_idx[t]),
      .full   (full[t]),
      .extra  (extra[t])
    );

    assign waddr[t] = wr_buf_q ? AW'(wr_idx[t]) + BUF_OFS : AW'(wr_idx[t]);

    pixel_reorder_bank #(.DATA_W(DATA_W), .DEPTH(2 * PER_TAP)) u_bank (
      .clk   (clk),
      .we    (wr_en[t]),
      .waddr (waddr[t]),
      .wdata (tap_data[t*DATA_W +: DATA_W]),
      .raddr (raddr),
      .rdata (rdata[t])
    );
  end

  pixel_reorder_reader #(.LINE_PIX(LINE_PIX), .PER_TAP(PER_TAP)) u_reader (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (handoff),
    .load_buf  (wr_buf_q),
    .ready     (out_ready),
    .free      (reader_free),
    .out_valid (out_valid),
    .sol       (out_sol),
    .eol       (out_eol),
    .bank_sel  (bank_sel),
    .bank_addr (raddr)
  );

  assign out_data = rdata[bank_sel];
  assign overrun  = ovr_q;

  always_comb begin
    line_done = (&full) && !done_q;
    handoff   = line_done && reader_free;
    drop      = line_done && !reader_free;
    done_d    = line_start ? 1'b0 : (done_q || line_done);
    wr_buf_d  = handoff ? !wr_buf_q : wr_buf_q;
    ovr_d     = ovr_q || drop || (|extra);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      done_q   <= 1'b0;
      wr_buf_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      done_q   <= done_d;
      wr_buf_q <= wr_buf_d;
      ovr_q    <= ovr_d;
    end
  end

  // R6: a stalled pixel holds its value
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a handed-off line starts streaming at pixel 1 next cycle
  p_handoff_starts_r8: assert property (@(posedge clk) disable iff (!rst_s)
    handoff |=> (out_valid && out_sol));

  // R10: a line completing against a busy reader raises the flag
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_s)
    ((&full) && !done_q && !reader_free) |=> overrun);

  // R11: the flag never clears outside reset
  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_s)
    overrun |=> overrun);
endmodule

// File: tb/pixel_reorder_test.sv
`timescale 1ns/1ps
module pixel_reorder_test;
  localparam int L  = 240;
  localparam int DW = 12;
  localparam int Q  = L / 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_start = 1'b0;
  logic [3:0]      tap_valid = '0;
  logic [4*DW-1:0] tap_data = '0;
  logic            out_ready = 1'b0;
  logic            out_valid, out_sol, out_eol, overrun;
  logic [DW-1:0]   out_data;

  always #2.5 clk = ~clk;

  pixel_reorder #(.LINE_PIX(L), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .tap_valid(tap_valid), .tap_data(tap_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
    .out_eol(out_eol), .overrun(overrun)
  );

  int checks = 0;
  int fails = 0;
  int exp_count = 0;
  int beats = 0;
  int cycles = 0;
  int ready_mode = 1;
  int ln, pos;
  logic          prev_stall = 1'b0;
  logic [DW-1:0] prev_data;
  logic [DW-1:0] exp_mem [0:7][0:L-1];
  logic [DW-1:0] cur [0:L-1];

  function automatic int tap_pix(int t, int k);
    case (t)
      0:       return 2*k - 1;
      1:       return 2*k;
      2:       return L + 1 - 2*k;
      default: return L + 2 - 2*k;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor and watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", "run did not finish", cycles, 150000);
      summary();
    end
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R6", "stalled pixel held",
              int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        ln  = beats / L;
        pos = beats % L;
        if (ln >= exp_count) begin
          check(1'b0, "R10", "beat beyond expected lines", beats, exp_count*L);
        end else begin
          check(out_data == exp_mem[ln%8][pos], (pos < L/2) ? "R2" : "R3",
                $sformatf("pixel %0d (R6 order)", pos+1),
                int'(out_data), int'(exp_mem[ln%8][pos]));
          check(out_sol == (pos == 0), "R7", "sol marker", int'(out_sol), int'(pos == 0));
          check(out_eol == (pos == L-1), "R7", "eol marker", int'(out_eol), int'(pos == L-1));
        end
        beats++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end else begin
      prev_stall = 1'b0;
    end
  end

  // downstream ready: 0 random, 1 always, 2 never
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0:       out_ready = (($urandom % 4) != 0);
      1:       out_ready = 1'b1;
      default: out_ready = 1'b0;
    endcase
  end

  task automatic pulse_start();
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
  endtask

  task automatic make_line(bit directed);
    for (int i = 0; i < L; i++)
      cur[i] = directed ? DW'(i + 1) : DW'($urandom);
  endtask

  task automatic commit();
    for (int i = 0; i < L; i++) exp_mem[exp_count%8][i] = cur[i];
    exp_count++;
  endtask

  // mode 0 one tap after another, 1 lockstep, 2 random, 3 random with gaps
  task automatic feed_line(int mode);
    int  k [4];
    bit  more;
    for (int t = 0; t < 4; t++) k[t] = 1;
    do begin
      @(posedge clk); #1;
      tap_valid = '0;
      for (int t = 0; t < 4; t++) begin
        bit go;
        case (mode)
          0:       go = (t == 0 || k[t-1] > Q);
          1:       go = 1'b1;
          default: go = ($urandom % 2) == 1;
        endcase
        if (k[t] <= Q && go) begin
          tap_valid[t] = 1'b1;
          tap_data[t*DW +: DW] = cur[tap_pix(t, k[t]) - 1];
          k[t]++;
        end
      end
      if (mode == 3) begin
        @(posedge clk); #1 tap_valid = '0;
        repeat (3) @(posedge clk);
      end
      more = 1'b0;
      for (int t = 0; t < 4; t++) if (k[t] <= Q) more = 1'b1;
    end while (more);
    @(posedge clk); #1 tap_valid = '0;
  endtask

  task automatic wait_idle(string req);
    while (beats < exp_count*L) @(negedge clk);
    repeat (3) @(negedge clk);
    check(!out_valid, req, "port idle after expected lines", int'(out_valid), 0);
    check(beats == exp_count*L, req, "beat total", beats, exp_count*L);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(!overrun, "R1", "overrun after reset", int'(overrun), 0);

    // R4: sequential taps, directed pattern, random ready
    ready_mode = 0;
    pulse_start(); make_line(1'b1); commit(); feed_line(0); wait_idle("R4");
    // R4: lockstep taps
    pulse_start(); make_line(1'b0); commit(); feed_line(1); wait_idle("R4");
    // R4: random interleave
    pulse_start(); make_line(1'b0); commit(); feed_line(2); wait_idle("R4");
    check(!overrun, "R4", "no overrun on clean lines", int'(overrun), 0);

    // R5: partial line abandoned by line_start
    pulse_start(); make_line(1'b0);
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      tap_valid = 4'($urandom);
      tap_data  = (4*DW)'($urandom);
    end
    @(posedge clk); #1 tap_valid = '0;
    repeat (5) @(negedge clk);
    check(!out_valid, "R5", "partial line produces no output", int'(out_valid), 0);
    pulse_start(); make_line(1'b0); commit(); feed_line(2); wait_idle("R5");

    // R8: second line fills while first is read
    ready_mode = 1;
    pulse_start(); make_line(1'b0); commit(); feed_line(1);
    pulse_start(); make_line(1'b0); commit(); feed_line(3);
    wait_idle("R8");
    check(!overrun, "R8", "overlap without overrun", int'(overrun), 0);

    // R9: extra sample after completion
    pulse_start(); make_line(1'b0); commit(); feed_line(1);
    repeat (2) @(posedge clk);
    #1 tap_valid = 4'b0001; tap_data = '1;
    @(posedge clk); #1 tap_valid = '0;
    wait_idle("R9");
    check(overrun, "R9", "extra sample flagged", int'(overrun), 1);

    // R11: flag survives line_start and a further line
    pulse_start(); make_line(1'b0); commit(); feed_line(2); wait_idle("R11");
    check(overrun, "R11", "overrun sticky", int'(overrun), 1);
    do_reset();
    @(negedge clk);
    check(!overrun, "R1", "overrun cleared by reset", int'(overrun), 0);

    // R10: line completes while reader stalled
    ready_mode = 2;
    pulse_start(); make_line(1'b0); commit(); feed_line(1);
    pulse_start(); make_line(1'b0); feed_line(1);
    repeat (3) @(negedge clk);
    check(overrun, "R10", "busy-reader drop flagged", int'(overrun), 1);
    check(out_valid && out_sol, "R10", "first line still at pixel 1",
          int'(out_valid && out_sol), 1);
    ready_mode = 1;
    wait_idle("R10");

    // random mix
    for (int n = 0; n < 4; n++) begin
      ready_mode = n % 2;
      pulse_start(); make_line(1'b0); commit(); feed_line(int'($urandom % 3));
      wait_idle("R4");
    end

    summary();
  end
endmodule